// File: doc/BRIEF.md
# Fibonacci Shift-Register Sequence Generator with Asynchronous Seeding

This block is a serial-shift linear feedback shift register in the Fibonacci arrangement. On every rising clock edge each stage hands its bit to the stage above it. The lowest stage takes in the XOR of a chosen set of tapped stages. The tap set is a parameter: a list of stage indices. The register is one stage longer than the highest index in that list. With the default taps {2,4} the register has five stages and the feedback is Q2 XOR Q4.

A starting pattern is forced in through per-bit asynchronous preset and clear lines. While `init_i` is high, every bit whose seed value is 1 is preset and every bit whose seed value is 0 is cleared. This happens at once, with no clock edge needed, and the pattern holds until `init_i` falls. After that the register runs freely.

The output is the whole state vector, plus a serial bit taken from the top stage. A flag marks the all-zero pattern, because XOR feedback cannot leave that pattern. A synchronous active-low reset reloads a parameter pattern, so the block also starts from a known non-zero state when it is not seeded.

Top module: `fib_lfsr`

## Requirements
- R1: The register has (highest tap index + 1) stages. With the default taps {2,4} there are 5 stages, so a single 1 placed in stage 0 first shows on `serial_o` after exactly 4 shifting edges.
- R2: While `init_i` is high, `state_o` equals `seed_i` without waiting for a clock edge. Bit i is preset when seed_i[i] is 1 and cleared when it is 0.
- R3: While `init_i` stays high, clock edges leave `state_o` at `seed_i`.
- R4: With `init_i` low and `rst_n` high, each rising edge moves stage i into stage i+1 for every i from 0 to N-2.
- R5: On the same edges, stage 0 takes the XOR of the tapped stages. With default taps, the next state is {Q[3:0], Q2 ^ Q4}. Seeding with 9 (Q0 and Q3 set) gives this sequence for at least 20 edges.
- R6: `serial_o` always equals the top stage, state_o[N-1].
- R7: With `init_i` low, a rising edge that sees `rst_n` low loads `RESET_SEED` (default 1).
- R8: `init_i` overrides `rst_n`: while both are active, the state is `seed_i`.
- R9: An all-zero state stays all-zero on every shifting edge. `stuck_o` is 1 exactly when `state_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, loads RESET_SEED |
| init_i | input | 1 | Asynchronous active-high seeding control |
| seed_i | input | STAGES | Pattern forced into the register while init_i is high |
| state_o | output | STAGES | Full register contents, Q[N-1:0] |
| serial_o | output | 1 | Serial output, top stage Q[N-1] |
| stuck_o | output | 1 | High when the register holds all zeros |

## Verification
The assertions sample at the rising clock edge. They assume that `init_i` and `seed_i` change only away from that edge, and that an `init_i` pulse spans at least one edge. Without that, a seeding pulse that lands and ends between two edges could disturb the state, and the shift and feedback checks would not see it. The bench drives every input on the falling edge and keeps each seeding pulse over one or more rising edges. The instant effect of seeding is checked at the ports in the half cycle before any edge.

// File: rtl/lfsr_pkg.sv
// Package: constant helpers that turn a packed list of tap indices into a
// stage count and a tap mask. Assumes each index fits in 8 bits and at most
// MAX_TAPS indices are supplied; the list is zero-extended to LIST_W bits.
package lfsr_pkg;

    localparam int TAP_W    = 8;
    localparam int MAX_TAPS = 32;
    localparam int LIST_W   = TAP_W * MAX_TAPS;
    localparam int MASK_W   = 256;

    // Highest tap index found among the first cnt fields of the list.
    function automatic int max_tap(input logic [LIST_W-1:0] list, input int cnt);
        int top;
        top = 0;
        for (int k = 0; k < MAX_TAPS; k++) begin
            if (k < cnt && int'(list[k*TAP_W +: TAP_W]) > top) begin
                top = int'(list[k*TAP_W +: TAP_W]);
            end
        end
        return top;
    endfunction

    // One-hot OR of all listed tap positions.
    function automatic logic [MASK_W-1:0] tap_mask(input logic [LIST_W-1:0] list, input int cnt);
        logic [MASK_W-1:0] m;
        m = '0;
        for (int k = 0; k < MAX_TAPS; k++) begin
            if (k < cnt) begin
                m[list[k*TAP_W +: TAP_W]] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/lfsr_cell.sv
// Module: one register stage with asynchronous preset and clear, plus a
// synchronous active-low reload of a fixed bit. Assumes set_a and clr_a are
// never high together (clear wins if they are).
module lfsr_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_a,
    input  logic clr_a,
    input  logic d_i,
    output logic q_o
);

    // Stage storage: async force first, then sync reload, then shift in d_i.
    always_ff @(posedge clk or posedge set_a or posedge clr_a) begin
        if (clr_a) begin
            q_o <= 1'b0;
        end else if (set_a) begin
            q_o <= 1'b1;
        end else if (!rst_n) begin
            q_o <= RST_VAL;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/lfsr_feedback.sv
// Module: XOR of the tapped stages, driving stage 0's next value. Assumes
// TAP_MASK has at least one bit set inside the N stages.
module lfsr_feedback #(
    parameter int          N        = 5,
    parameter logic [N-1:0] TAP_MASK = 5'b10100
) (
    input  logic [N-1:0] state_i,
    output logic         fb_o
);

    logic [N-1:0] picked;

    // Gate each stage by its tap bit.
    for (genvar i = 0; i < N; i++) begin : g_pick
        if (TAP_MASK[i]) begin : g_on
            assign picked[i] = state_i[i];
        end else begin : g_off
            assign picked[i] = 1'b0;
        end
    end

    // Reduce the gated stages to one parity bit.
    always_comb begin
        fb_o = ^picked;
    end

endmodule

// File: rtl/fib_lfsr.sv
// Module: Fibonacci LFSR whose length follows from its tap list. It is seeded
// asynchronously through per-bit preset/clear while init_i is high. Assumes
// init_i and seed_i change away from the rising clock edge.
module fib_lfsr #(
    parameter int                                   TAP_COUNT  = 2,
    parameter logic [TAP_COUNT*lfsr_pkg::TAP_W-1:0] TAP_LIST   = {8'd4, 8'd2},
    parameter logic [lfsr_pkg::MASK_W-1:0]          RESET_SEED = 256'd1,
    localparam int STAGES = lfsr_pkg::max_tap(lfsr_pkg::LIST_W'(TAP_LIST), TAP_COUNT) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [STAGES-1:0] seed_i,
    output logic [STAGES-1:0] state_o,
    output logic              serial_o,
    output logic              stuck_o
);

    localparam logic [lfsr_pkg::MASK_W-1:0] TAP_MASK =
        lfsr_pkg::tap_mask(lfsr_pkg::LIST_W'(TAP_LIST), TAP_COUNT);

    logic [STAGES-1:0] set_a;
    logic [STAGES-1:0] clr_a;
    logic [STAGES-1:0] d_in;
    logic              fb;

    // Split the seed into per-bit preset and clear lines.
    always_comb begin
        set_a = {STAGES{init_i}} &  seed_i;
        clr_a = {STAGES{init_i}} & ~seed_i;
    end

    lfsr_feedback #(
        .N        (STAGES),
        .TAP_MASK (TAP_MASK[STAGES-1:0])
    ) u_fb (
        .state_i (state_o),
        .fb_o    (fb)
    );

    // Chain: stage 0 takes feedback, stage i takes stage i-1.
    always_comb begin
        d_in = {state_o[STAGES-2:0], fb};
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        lfsr_cell #(
            .RST_VAL (RESET_SEED[i])
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_a (set_a[i]),
            .clr_a (clr_a[i]),
            .d_i   (d_in[i]),
            .q_o   (state_o[i])
        );
    end

    // Serial tap and lock-up flag.
    always_comb begin
        serial_o = state_o[STAGES-1];
        stuck_o  = (state_o == '0);
    end

endmodule

// File: rtl/fib_lfsr_chk.sv
// Module: property checker bound to fib_lfsr. Assumes init_i and seed_i move
// only between rising edges and that a seeding pulse covers one or more edges.
module fib_lfsr_chk #(
    parameter int           N          = 5,
    parameter logic [N-1:0] TAP_MASK   = 5'b10100,
    parameter logic [N-1:0] RESET_SEED = 5'd1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         init_i,
    input logic [N-1:0] seed_i,
    input logic [N-1:0] state_o
);

    logic started = 1'b0;

    // Marks that one edge has passed, so $past has a real value.
    always_ff @(posedge clk) begin
        started <= 1'b1;
    end

    p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |-> state_o == seed_i);

    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !init_i && !$past(init_i) && $past(rst_n))
        |-> state_o[N-1:1] == $past(state_o[N-2:0]));

    p_feedback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !init_i && !$past(init_i) && $past(rst_n))
        |-> state_o[0] == ^($past(state_o) & TAP_MASK));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !$past(rst_n) && !$past(init_i) && !init_i)
        |-> state_o == RESET_SEED);

    p_lockup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(rst_n) && !$past(init_i) && !init_i && $past(state_o) == '0)
        |-> state_o == '0);

endmodule

bind fib_lfsr fib_lfsr_chk #(
    .N          (STAGES),
    .TAP_MASK   (TAP_MASK[STAGES-1:0]),
    .RESET_SEED (RESET_SEED[STAGES-1:0])
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .init_i  (init_i),
    .seed_i  (seed_i),
    .state_o (state_o)
);

// File: tb/tb_fib_lfsr.sv
// Directed bench for fib_lfsr with default taps {2,4}. Inputs are driven on
// the falling edge; outputs are sampled 2 ns after the rising edge.
module tb_fib_lfsr;

    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_i = 1'b0;
    logic [N-1:0] seed_i = '0;
    logic [N-1:0] state_o;
    logic         serial_o;
    logic         stuck_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    fib_lfsr dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (init_i),
        .seed_i   (seed_i),
        .state_o  (state_o),
        .serial_o (serial_o),
        .stuck_o  (stuck_o)
    );

    function automatic logic [N-1:0] step(input logic [N-1:0] s);
        return {s[3:0], s[2] ^ s[4]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0; init_i = 1'b0;
        tick(); tick();
        chk("R7 reset load", state_o, 5'd1);
        chk("R9 flag clear", stuck_o, 1'b0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_stage_count();
        int edges = 0;
        while (serial_o !== 1'b1 && edges < 10) begin
            tick();
            edges++;
        end
        chk("R1 stage count", edges, 4);
        chk("R6 serial top", serial_o, state_o[N-1]);
    endtask

    task automatic run_check(input logic [N-1:0] start, input int cycles, input string tag);
        logic [N-1:0] s = start;
        for (int c = 0; c < cycles; c++) begin
            tick();
            s = step(s);
            chk(tag, state_o, s);
            chk("R6 serial", serial_o, s[N-1]);
            chk("R9 flag", stuck_o, s == '0);
        end
    endtask

    task automatic t_seed_nine();
        @(negedge clk); seed_i = 5'd9; init_i = 1'b1;
        #1;
        chk("R2 async seed", state_o, 5'd9);
        tick(); tick();
        chk("R3 seed hold", state_o, 5'd9);
        @(negedge clk); init_i = 1'b0;
        run_check(5'd9, 20, "R4 R5 seed 9 run");
    endtask

    task automatic t_reseed_midrun();
        @(negedge clk); seed_i = 5'b10110; init_i = 1'b1;
        #1;
        chk("R2 reseed", state_o, 5'b10110);
        chk("R6 serial seeded", serial_o, 1'b1);
        tick();
        @(negedge clk); init_i = 1'b0;
        run_check(5'b10110, 10, "R5 reseed run");
    endtask

    task automatic t_zero_lock();
        @(negedge clk); seed_i = 5'd0; init_i = 1'b1;
        tick();
        @(negedge clk); init_i = 1'b0;
        for (int c = 0; c < 8; c++) begin
            tick();
            chk("R9 lockup", state_o, 5'd0);
        end
        chk("R9 stuck flag", stuck_o, 1'b1);
    endtask

    task automatic t_init_beats_reset();
        @(negedge clk); seed_i = 5'b11010; init_i = 1'b1; rst_n = 1'b0;
        tick(); tick();
        chk("R8 init over reset", state_o, 5'b11010);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); init_i = 1'b0;
    endtask

    task automatic t_reset_midrun();
        tick(); tick();
        @(negedge clk); rst_n = 1'b0;
        tick();
        chk("R7 midrun reload", state_o, 5'd1);
        @(negedge clk); rst_n = 1'b1;
        run_check(5'd1, 6, "R4 after reload");
    endtask

    initial begin
        #1_600_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_stage_count();
        t_seed_nine();
        t_reseed_midrun();
        t_zero_lock();
        t_init_beats_reset();
        t_reset_midrun();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule